// File: doc/BRIEF.md
# Handshaked Disk Write Serializer

This block turns bytes supplied by a processor into a serial bit stream for a floppy drive's write-data line. Bits go out most significant first, one per bit cell. The length of a bit cell is a programmable number of clocks. Each 1 bit produces a single-clock pulse, which marks a flux transition. A 0 bit produces nothing.

A one-byte holding buffer sits in front of the shift register. The processor refills it while the current byte is being shifted out. Two flags form the handshake with the processor. `bufReady` shows that the buffer may take a new byte. `noUnderrun` drops when a byte boundary arrives and no new byte has been supplied.

Two mode switches select the operating state. A write session starts only when the switches move from the sense state (both high) to the write-load state (`swWrite` high, `swLoad` low). Once started, the session ignores the switches and ends by itself at the first underrun.

Top module: `flux_write_serializer`

## Requirements
- R1: After reset, `writeActive` and `wrPulse` are 0, and `bufReady` and `noUnderrun` are 1.
- R2: A write session starts at a clock edge that samples `swWrite`=1 and `swLoad`=0, provided the edge before it sampled `swWrite`=1 and `swLoad`=1 and no session is active. From that edge on, `writeActive` is 1.
- R3: Reaching `swWrite`=1, `swLoad`=0 from any state other than both-high (for example both low, or `swLoad`=1 with `swWrite`=0) does not start a session.
- R4: At session start, the buffered byte moves into the shift register, `bufReady` and `noUnderrun` are set to 1, the bit count becomes 8 and the bit-cell counter restarts at zero.
- R5: Call the start edge E and the cell length L. Bit k of the stream (k=0 is bit 7 of the first byte, and bits run MSB first through each byte) ends at edge E+(k+1)*L. If that bit is 1, `wrPulse` is high for exactly the one clock cycle after that edge. `wrPulse` is 0 at all other times.
- R6: A `byteWrEn` strobe stores `byteWrData` in the buffer, and `bufReady` reads 0 from the next cycle on. If the strobe coincides with a set event (session start or byte reload), the strobe wins.
- R7: When the eighth bit of a byte ends and `bufReady` is 0, the buffered byte loads with no gap. The next bit ends L clocks later, and `bufReady` returns to 1 at that edge.
- R8: When the eighth bit of a byte ends and `bufReady` is still 1, that edge clears both `noUnderrun` and `writeActive`. No further pulses follow.
- R9: Switch changes during an active session have no effect on the session. The only way a session ends is an underrun.
- R10: After an underrun, holding the write-load switch state, or reaching it from both-low, does not restart a session. A fresh both-high to write-load transition does restart one.
- R11: `cellLen` sets the cell length L in clocks, for any value from 1 up. It must not be changed during a session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| swLoad | input | 1 | Mode switch paired with `swWrite`; both high selects the sense state |
| swWrite | input | 1 | Mode switch; high with `swLoad` low selects write-load |
| byteWrEn | input | 1 | Processor strobe that writes the holding buffer |
| byteWrData | input | DATA_W | Byte written by `byteWrEn` |
| cellLen | input | CELL_W | Bit-cell length in clocks, 1 or more |
| wrPulse | output | 1 | One-clock pulse for each 1 bit at the end of its cell |
| writeActive | output | 1 | A write session is in progress |
| bufReady | output | 1 | The holding buffer may take a new byte |
| noUnderrun | output | 1 | Low once a session has ended by underrun |

## Verification
All results are registered. A session is visible one edge after the write-load state is sampled, a strobe clears `bufReady` one edge later, and the pulse for stream bit k follows edge E+(k+1)*L. An underrun clears both flags at the edge that ends the last bit. The bench drives inputs on the falling clock edge and samples on the falling edge after each rising edge. It numbers the cycles from the start edge E and compares every cycle of the pulse train and of `writeActive` against a trace computed from the byte values and L. The handshake flags are checked exactly at the cycles where they must change.

// File: rtl/fws_pkg.sv
package fws_pkg;
  // Strobes from the session control to the serial datapath
  typedef struct packed {
    logic load;    // move buffered byte into shifter, reset bit count
    logic shift;   // end of a bit cell: emit MSB and shift left
    logic cntClr;  // restart the bit-cell counter
    logic cntEn;   // advance the bit-cell counter
  } fwsStrobes_t;
endpackage

// File: rtl/fws_datapath.sv
module fws_datapath
  import fws_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CELL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fwsStrobes_t       strobes,
  input  logic [CELL_W-1:0] cellLen,
  input  logic              byteWrEn,
  input  logic [DATA_W-1:0] byteWrData,
  output logic              cellEnd,
  output logic              lastBit,
  output logic              wrPulse
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] nextByte;
  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitsLeft;
  logic [CELL_W-1:0] cellCnt;

  assign cellEnd = (cellCnt == cellLen - CELL_W'(1));
  assign lastBit = (bitsLeft == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextByte <= '0;
      shiftReg <= '0;
      bitsLeft <= '0;
      cellCnt  <= '0;
      wrPulse  <= 1'b0;
    end else begin
      if (byteWrEn) nextByte <= byteWrData;

      if (strobes.load)       shiftReg <= nextByte;
      else if (strobes.shift) shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};

      if (strobes.load)       bitsLeft <= CNT_W'(DATA_W);
      else if (strobes.shift) bitsLeft <= bitsLeft - CNT_W'(1);

      if (strobes.cntClr)     cellCnt <= '0;
      else if (strobes.cntEn) cellCnt <= cellCnt + CELL_W'(1);

      wrPulse <= strobes.shift & shiftReg[DATA_W-1];
    end
  end
endmodule

// File: rtl/fws_control.sv
module fws_control
  import fws_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        swLoad,
  input  logic        swWrite,
  input  logic        byteWrEn,
  input  logic        cellEnd,
  input  logic        lastBit,
  output fwsStrobes_t strobes,
  output logic        writeActive,
  output logic        bufReady,
  output logic        noUnderrun
);
  logic prevSense;
  logic entry, endCell, byteEnd, reload, underrun;

  assign entry    = !writeActive && prevSense && swWrite && !swLoad;
  assign endCell  = writeActive && cellEnd;
  assign byteEnd  = endCell && lastBit;
  assign reload   = byteEnd && !bufReady;
  assign underrun = byteEnd && bufReady;

  always_comb begin
    strobes.load   = entry || reload;
    strobes.shift  = endCell;
    strobes.cntClr = entry || endCell;
    strobes.cntEn  = writeActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSense   <= 1'b0;
      writeActive <= 1'b0;
      bufReady    <= 1'b1;
      noUnderrun  <= 1'b1;
    end else begin
      prevSense <= swLoad && swWrite;

      if (entry)         writeActive <= 1'b1;
      else if (underrun) writeActive <= 1'b0;

      if (byteWrEn)               bufReady <= 1'b0;
      else if (entry || reload)   bufReady <= 1'b1;

      if (entry)         noUnderrun <= 1'b1;
      else if (underrun) noUnderrun <= 1'b0;
    end
  end
endmodule

// File: rtl/flux_write_serializer.sv
module flux_write_serializer
  import fws_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CELL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swLoad,
  input  logic              swWrite,
  input  logic              byteWrEn,
  input  logic [DATA_W-1:0] byteWrData,
  input  logic [CELL_W-1:0] cellLen,
  output logic              wrPulse,
  output logic              writeActive,
  output logic              bufReady,
  output logic              noUnderrun
);
  fwsStrobes_t strobes;
  logic cellEnd, lastBit;

  fws_control u_ctl (
    .clk(clk), .rstN(rstN), .swLoad(swLoad), .swWrite(swWrite),
    .byteWrEn(byteWrEn), .cellEnd(cellEnd), .lastBit(lastBit),
    .strobes(strobes), .writeActive(writeActive), .bufReady(bufReady),
    .noUnderrun(noUnderrun)
  );

  fws_datapath #(.DATA_W(DATA_W), .CELL_W(CELL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cellLen(cellLen),
    .byteWrEn(byteWrEn), .byteWrData(byteWrData), .cellEnd(cellEnd),
    .lastBit(lastBit), .wrPulse(wrPulse)
  );
endmodule

// File: rtl/fws_chk.sv
module fws_chk (
  input logic clk,
  input logic rstN,
  input logic swLoad,
  input logic swWrite,
  input logic byteWrEn,
  input logic wrPulse,
  input logic writeActive,
  input logic bufReady,
  input logic noUnderrun
);
  // R5
  pulse_in_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |-> $past(writeActive));

  // R2
  entry_from_sense_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeActive) |-> ($past(swWrite && !swLoad) && $past(swWrite && swLoad, 2)));

  // R4
  entry_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeActive) |-> noUnderrun);

  // R6
  strobe_clears_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteWrEn |=> !bufReady);

  // R8
  underrun_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(noUnderrun) |-> $fell(writeActive));

  // R9
  only_underrun_exits_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(writeActive) |-> $fell(noUnderrun));
endmodule

bind flux_write_serializer fws_chk u_chk (
  .clk(clk), .rstN(rstN), .swLoad(swLoad), .swWrite(swWrite),
  .byteWrEn(byteWrEn), .wrPulse(wrPulse), .writeActive(writeActive),
  .bufReady(bufReady), .noUnderrun(noUnderrun)
);

// File: tb/flux_write_serializer_tb.sv
module flux_write_serializer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swLoad = 1'b0, swWrite = 1'b0, byteWrEn = 1'b0;
  logic [7:0] byteWrData = '0;
  logic [7:0] cellLen = 8'd4;
  logic wrPulse, writeActive, bufReady, noUnderrun;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flux_write_serializer u_dut (
    .clk(clk), .rstN(rstN), .swLoad(swLoad), .swWrite(swWrite),
    .byteWrEn(byteWrEn), .byteWrData(byteWrData), .cellLen(cellLen),
    .wrPulse(wrPulse), .writeActive(writeActive), .bufReady(bufReady),
    .noUnderrun(noUnderrun)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic setSw(input logic ld, input logic wr);
    swLoad = ld; swWrite = wr;
  endtask

  task automatic tReset();
    chk(writeActive == 1'b0, "R1 writeActive", writeActive, 0);
    chk(wrPulse == 1'b0, "R1 wrPulse", wrPulse, 0);
    chk(bufReady == 1'b1, "R1 bufReady", bufReady, 1);
    chk(noUnderrun == 1'b1, "R1 noUnderrun", noUnderrun, 1);
  endtask

  task automatic tNoEntry();
    setSw(0, 0); step(); step();
    setSw(0, 1); step(); step(); step();
    chk(writeActive == 1'b0, "R3 from both-low", writeActive, 0);
    setSw(1, 0); step(); step();
    setSw(0, 1); step(); step(); step();
    chk(writeActive == 1'b0, "R3 from load-only", writeActive, 0);
    setSw(0, 0); step();
  endtask

  // Full session: preload b0, enter, optionally supply b1, run to underrun
  task automatic tStream(input logic [7:0] b0, input logic [7:0] b1, input bit two,
                         input int L, input bit junk, input string tag);
    int nb = two ? 2 : 1;
    int total = 8 * nb * L;
    int mism = 0, firstN = -1;
    logic [15:0] stream = {b0, b1};
    cellLen = 8'(L);
    byteWrData = b0; byteWrEn = 1'b1; step(); byteWrEn = 1'b0; step();
    setSw(1, 1); step();
    setSw(0, 1); step();                       // edge E just passed; n = 0
    chk(writeActive == 1'b1, "R2 session start", writeActive, 1);
    chk(bufReady == 1'b1 && noUnderrun == 1'b1, "R4 flags at start",
        {bufReady, noUnderrun}, 3);
    for (int n = 0; n <= total + 3; n++) begin
      bit expP = 1'b0;
      bit expA = (n < total);
      if (n > 0 && n % L == 0 && n / L <= 8 * nb) expP = stream[15 - (n / L - 1)];
      if (wrPulse !== expP || writeActive !== expA) begin
        mism++;
        if (firstN < 0) firstN = n;
      end
      if (two && n == 3)
        chk(bufReady == 1'b0, "R6 strobe clears ready", bufReady, 0);
      if (two && n == 8 * L)
        chk(bufReady == 1'b1, "R7 reload sets ready", bufReady, 1);
      if (n == total)
        chk(noUnderrun == 1'b0 && writeActive == 1'b0, "R8 underrun ends session",
            {noUnderrun, writeActive}, 0);
      // inputs for the next edge
      byteWrEn = (two && n == 2);
      byteWrData = b1;
      if (junk) begin
        if (n < total - 3) setSw(n[0], n[1]);
        else setSw(0, 0);
      end
      step();
    end
    byteWrEn = 1'b0;
    chk(mism == 0, tag, mism, 0);
    if (mism != 0) $display("  first trace mismatch at cycle %0d", firstN);
  endtask

  task automatic tNoRestart();
    setSw(0, 1); step(); step(); step(); step();
    chk(writeActive == 1'b0, "R10 hold write-load", writeActive, 0);
    setSw(0, 0); step(); setSw(0, 1); step(); step();
    chk(writeActive == 1'b0, "R10 from both-low", writeActive, 0);
    setSw(1, 1); step(); setSw(0, 1); step();
    chk(writeActive == 1'b1 && noUnderrun == 1'b1, "R10 fresh transition restarts",
        {writeActive, noUnderrun}, 3);
    repeat (8 * 2 + 2) step();               // cellLen 2: run to underrun
    chk(writeActive == 1'b0, "R10 second session underruns", writeActive, 0);
    setSw(0, 0); step();
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    tReset();
    rstN = 1'b1; step();
    tReset();
    tNoEntry();
    tStream(8'hA5, 8'h3C, 1'b1, 4, 1'b0, "R5 R7 trace two bytes L=4");
    tStream(8'hC3, 8'h00, 1'b0, 1, 1'b0, "R11 trace L=1");
    tStream(8'h81, 8'h7E, 1'b1, 3, 1'b1, "R9 trace with switch noise L=3");
    tStream(8'hFF, 8'h00, 1'b0, 5, 1'b0, "R11 trace L=5 all ones");
    cellLen = 8'd2;
    tNoRestart();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule